// File: doc/BRIEF.md
# Handshaked Data Memory with Refusal

A word-addressed data memory slave for a processor datapath. Reads and writes arrive on two independent request ports. Each port has its own one-cycle acknowledge. Any request may be turned away, and a requester must present the same operation again, cycle after cycle, until an acknowledge comes back. The storage holds 34-bit words and every location starts at zero.

The memory decides whether to accept a request in the cycle the request is sampled. An accepted write changes the addressed word at that clock edge. An accepted read places the stored word on the read data bus in the following cycle, together with the read acknowledge. When the memory turns a request away, there is no acknowledge and, for a write, no change to storage. In every cycle that carries no read acknowledge, the read data bus rests at all ones. A 16-bit LFSR, free-running from reset, decides refusals in a fixed and repeatable pattern. A parameter switches refusal off so that the memory accepts everything.

Top module: `dmem_handshake`

## Requirements
- R1: Every location reads as zero until an accepted write changes it.
- R2: A write sampled with a request and accepted gets `wr_ack` high in the next cycle, and later reads of that address return the written word.
- R3: A write request that gets no `wr_ack` in the next cycle leaves the addressed word unchanged.
- R4: A read sampled with a request and accepted gets `rd_ack` high in the next cycle, and `rd_data` carries the stored word in that same cycle.
- R5: In every cycle where `rd_ack` is low, whether the read was refused or none was requested, `rd_data` equals 0x3FFFFFFFF (all 34 bits set).
- R6: An acknowledge is high only in the cycle after a clock edge that sampled the matching request.
- R7: When a read and a write to the same address are both accepted at the same edge, the read returns the word as it was before that write.
- R8: A read and a write to different addresses can both be accepted at the same edge.
- R9: With `ALWAYS_ACCEPT` set, every request is acknowledged in the next cycle.
- R10: In the first cycle after synchronous reset is released, both acknowledges are low and `rd_data` is all ones.
- R11: With default parameters, the refusal pattern both accepts and refuses requests of each kind over a long run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request |
| rd_addr | input | 12 | Read word address |
| rd_data | output | 34 | Read word, all ones when no read acknowledge |
| rd_ack | output | 1 | Read accepted, data valid this cycle |
| wr_req | input | 1 | Write request |
| wr_addr | input | 12 | Write word address |
| wr_data | input | 34 | Word to write |
| wr_ack | output | 1 | Write accepted at the previous edge |

## Verification
The assertions assume that the requester keeps its request inputs at known values while reset is low. They do not assume that a request is held until it is acknowledged, because the memory must behave correctly even when a requester drops a refused request. The stimulus uses both styles. Directed operations retry until acknowledged, while random cycles raise one-shot requests on a small address window, so refused writes, same-address collisions and back-to-back requests all occur often.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int DATA_W_DEF = 34;
  localparam int ADDR_W_DEF = 12;
  localparam int LFSR_W_DEF = 16;
  localparam logic [LFSR_W_DEF-1:0] LFSR_TAPS_DEF = 16'hB400;
  localparam logic [LFSR_W_DEF-1:0] LFSR_SEED_DEF = 16'hACE1;

  typedef struct packed {
    logic rd;
    logic wr;
  } grant_t;
endpackage

// File: rtl/dmem_refusal.sv
module dmem_refusal
  import dmem_pkg::*;
#(
  parameter int              LFSR_W        = LFSR_W_DEF,
  parameter logic [LFSR_W-1:0] TAPS        = LFSR_TAPS_DEF,
  parameter logic [LFSR_W-1:0] SEED        = LFSR_SEED_DEF,
  parameter bit              ALWAYS_ACCEPT = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  output grant_t grant
);
  generate
    if (ALWAYS_ACCEPT) begin : g_open
      assign grant = '{rd: 1'b1, wr: 1'b1};
    end else begin : g_lfsr
      logic [LFSR_W-1:0] state;
      logic              feedback;

      assign feedback = ^(state & TAPS);

      always_ff @(posedge clk) begin
        if (rst) state <= SEED;
        else     state <= {state[LFSR_W-2:0], feedback};
      end

      // Each port is refused when its own pair of state bits is zero.
      assign grant.rd = |state[1:0];
      assign grant.wr = |state[3:2];
    end
  endgenerate
endmodule

// File: rtl/dmem_array.sv
module dmem_array #(
  parameter int DATA_W = 34,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Read-before-write: the registered read sees the pre-edge contents.
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '1;
    else if (rd_en) rd_data <= mem[rd_addr];
    else            rd_data <= '1;
  end
endmodule

// File: rtl/dmem_ack_gen.sv
module dmem_ack_gen
  import dmem_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   rd_req,
  input  logic   wr_req,
  input  grant_t grant,
  output logic   rd_fire,
  output logic   wr_fire,
  output logic   rd_ack,
  output logic   wr_ack
);
  assign rd_fire = rd_req & grant.rd;
  assign wr_fire = wr_req & grant.wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack <= 1'b0;
      wr_ack <= 1'b0;
    end else begin
      rd_ack <= rd_fire;
      wr_ack <= wr_fire;
    end
  end
endmodule

// File: rtl/dmem_handshake.sv
module dmem_handshake
  import dmem_pkg::*;
#(
  parameter int DATA_W        = DATA_W_DEF,
  parameter int ADDR_W        = ADDR_W_DEF,
  parameter bit ALWAYS_ACCEPT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ack,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ack
);
  grant_t grant;
  logic   rd_fire;
  logic   wr_fire;

  dmem_refusal #(.ALWAYS_ACCEPT(ALWAYS_ACCEPT)) u_refusal (
    .clk   (clk),
    .rst   (rst),
    .grant (grant)
  );

  dmem_ack_gen u_ack (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_req),
    .wr_req  (wr_req),
    .grant   (grant),
    .rd_fire (rd_fire),
    .wr_fire (wr_fire),
    .rd_ack  (rd_ack),
    .wr_ack  (wr_ack)
  );

  dmem_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_fire),
    .rd_addr (rd_addr),
    .wr_en   (wr_fire),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/dmem_handshake_chk.sv
module dmem_handshake_chk #(
  parameter int DATA_W        = 34,
  parameter bit ALWAYS_ACCEPT = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req,
  input logic              wr_req,
  input logic              rd_ack,
  input logic              wr_ack,
  input logic [DATA_W-1:0] rd_data
);
  a_r5_idle_ones: assert property (@(posedge clk) disable iff (rst)
    !rd_ack |-> rd_data == {DATA_W{1'b1}});

  a_r6_rd_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> $past(rd_req));

  a_r6_wr_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> $past(wr_req));

  a_r10_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_ack && !wr_ack && rd_data == {DATA_W{1'b1}}));

  generate
    if (ALWAYS_ACCEPT) begin : g_open
      a_r9_rd_always: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_ack);
      a_r9_wr_always: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> wr_ack);
    end
  endgenerate
endmodule

bind dmem_handshake dmem_handshake_chk #(
  .DATA_W(DATA_W), .ALWAYS_ACCEPT(ALWAYS_ACCEPT)
) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
  .rd_ack(rd_ack), .wr_ack(wr_ack), .rd_data(rd_data)
);

// File: tb/tb_dmem_handshake.sv
module tb_dmem_handshake;
  localparam int DW = 34;
  localparam int AW = 12;
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_req = 1'b0, wr_req = 1'b0;
  logic [AW-1:0] ra = '0, wa = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] d0_data, d1_data;
  logic d0_rack, d0_wack, d1_rack, d1_wack;

  int checks = 0, fails = 0;
  int rd_acc = 0, rd_ref = 0, wr_acc = 0, wr_ref = 0;
  bit done = 1'b0;
  logic [DW-1:0] model0 [1 << AW];
  logic [DW-1:0] model1 [1 << AW];

  always #4 clk = ~clk;

  dmem_handshake #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(ra), .rd_data(d0_data),
    .rd_ack(d0_rack), .wr_req(wr_req), .wr_addr(wa), .wr_data(wd), .wr_ack(d0_wack));

  dmem_handshake #(.DATA_W(DW), .ADDR_W(AW), .ALWAYS_ACCEPT(1'b1)) dut_open (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(ra), .rd_data(d1_data),
    .rd_ack(d1_rack), .wr_req(wr_req), .wr_addr(wa), .wr_data(wd), .wr_ack(d1_wack));

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, observe results one negedge later.
  task automatic step(input logic r, input logic w, input logic [AW-1:0] a_r,
                      input logic [AW-1:0] a_w, input logic [DW-1:0] d);
    rd_req = r; wr_req = w; ra = a_r; wa = a_w; wd = d;
    @(negedge clk);
    // main instance: acks only after a request (R6); data per R4/R5
    if (d0_rack) begin
      check("R6 rd_ack without request", DW'(r), DW'(1));
      check("R4/R1/R7 read data", d0_data, model0[a_r]);
      rd_acc++;
    end else begin
      check("R5 rd_data idle ones", d0_data, ONES);
      if (r) rd_ref++;
    end
    if (d0_wack) begin
      check("R6 wr_ack without request", DW'(w), DW'(1));
      model0[a_w] = d;
      wr_acc++;
    end else if (w) wr_ref++;  // R3: model left unchanged
    // always-accept instance (R9, R7, R8)
    check("R9 rd_ack", DW'(d1_rack), DW'(r));
    check("R9 wr_ack", DW'(d1_wack), DW'(w));
    check("R7/R8 open read data", d1_data, r ? model1[a_r] : ONES);
    if (w) model1[a_w] = d;
  endtask

  task automatic write_retry(input logic [AW-1:0] a, input logic [DW-1:0] d);
    for (int n = 0; n < 200; n++) begin
      step(1'b0, 1'b1, '0, a, d);
      if (d0_wack) return;
    end
    check("R2 write never acknowledged", 0, 1);
  endtask

  task automatic read_retry(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    for (int n = 0; n < 200; n++) begin
      step(1'b1, 1'b0, a, '0, '0);
      if (d0_rack) begin
        check(tag, d0_data, exp);
        return;
      end
    end
    check("R4 read never acknowledged", 0, 1);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      model0[i] = '0;
      model1[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: first cycle after reset
    check("R10 rd_ack", DW'(d0_rack), 0);
    check("R10 wr_ack", DW'(d0_wack), 0);
    check("R10 rd_data", d0_data, ONES);
    check("R10 open rd_data", d1_data, ONES);

    // R1: untouched location reads zero
    read_retry(12'd100, '0, "R1 power-up zero");
    read_retry(12'hFFF, '0, "R1 top address zero");
    // R2/R4: write then read back
    write_retry(12'd7, 34'h2_DEAD_BEEF);
    read_retry(12'd7, 34'h2_DEAD_BEEF, "R2 readback");
    write_retry(12'd0, ONES);
    read_retry(12'd0, ONES, "R4 all-ones word");
    step(1'b0, 1'b0, '0, '0, '0);
    check("R5 idle after read", d0_data, ONES);
    // R7 on open instance: same-address collision returns old word
    step(1'b1, 1'b1, 12'd7, 12'd7, 34'h1_2345_6789);
    check("R7 collision old data", d1_data, 34'h2_DEAD_BEEF);
    // R8 on open instance: different addresses together
    step(1'b1, 1'b1, 12'd7, 12'd8, 34'h0_0000_0055);
    check("R8 both acked", DW'({d1_rack, d1_wack}), DW'(2'b11));
    check("R8 read data", d1_data, 34'h1_2345_6789);

    // Random one-shot traffic on a small window (R3, R5, R6, R7)
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < 4000; c++) begin
      logic [AW-1:0] a1, a2;
      logic [DW-1:0] dd;
      a1 = AW'($urandom_range(0, 15));
      a2 = AW'($urandom_range(0, 15));
      dd = {2'($urandom), 32'($urandom)};
      step(1'($urandom), 1'($urandom), a1, a2, dd);
    end
    // R11: pattern both accepts and refuses
    check("R11 reads accepted", DW'(rd_acc > 0), 1);
    check("R11 reads refused", DW'(rd_ref > 0), 1);
    check("R11 writes accepted", DW'(wr_acc > 0), 1);
    check("R11 writes refused", DW'(wr_ref > 0), 1);
    // R3: every window word matches the ack-only model
    for (int i = 0; i < 16; i++) read_retry(AW'(i), model0[i], "R3 final sweep");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule